// File: doc/BRIEF.md
# PWM Channel Clock-Enable Generator

This block produces the timing strobes for a bank of eight PWM channels. Everything runs on the bus clock and no derived clock nets exist. A free-running prescale counter yields two power-of-two rate strobes, called A and B. Each of those strobes drives a reloadable even divider, and the dividers yield the scaled strobes SA and SB. For each channel, a select bit decides whether the channel is timed by its plain prescaled strobe or by its scaled strobe. The channel then receives a one-cycle enable pulse at the chosen rate.

The prescale counter halts in two cases: when freeze gating is enabled and the freeze signal is high, and when every channel is disabled. While it is halted, no strobe of any kind is produced. Channels 0, 1, 4 and 5 belong to the A side and channels 2, 3, 6 and 7 belong to the B side. A write to a scale value restarts that divider at once. The downstream period and duty counters consume the pulses.

Top module: `pwm_tick_gen`

## Requirements
- R1: With prescale code k (0..7) on `pre_sel_a_i`, a running A-side channel timed by its prescaled strobe pulses exactly every 2^k bus cycles.
- R2: The B-side prescale code `pre_sel_b_i` sets the B-side rate in the same way, and it is independent of the A-side code.
- R3: A channel timed by its scaled strobe pulses every 2^k × 2N bus cycles, where N is its side's 8-bit scale value. N = 0 stands for 256, which gives 2^k × 512.
- R4: Channels 0, 1, 4 and 5 take their timing from the A side (`pre_sel_a_i`, `scale_a_i`). Channels 2, 3, 6 and 7 take theirs from the B side.
- R5: Bit i of `src_scaled_i` selects the timing for channel i: 0 selects the prescaled strobe and 1 selects the scaled strobe.
- R6: While `frz_gate_i` and `freeze_i` are both 1, no channel pulses. When `frz_gate_i` is 0, `freeze_i` has no effect on the pulse rate.
- R7: While all bits of `ch_en_i` are 0, the prescaler is halted and no pulse appears on any output.
- R8: A channel whose enable bit is 0 never pulses, even while other channels are running.
- R9: A one-cycle write strobe (`scale_a_wr_i` or `scale_b_wr_i`) reloads that divider immediately. The first scaled pulse follows about 2N prescaled strobes after the write, not after the remainder of the old count.
- R10: While `rst` is high, and in the first cycle after it, every bit of `ch_tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Freeze mode indication |
| frz_gate_i | input | 1 | When 1, freeze_i halts the prescaler |
| ch_en_i | input | 8 | Per-channel enable |
| src_scaled_i | input | 8 | Per-channel timing source: 1 = scaled, 0 = prescaled |
| pre_sel_a_i | input | 3 | A-side prescale code k, giving divide by 2^k |
| pre_sel_b_i | input | 3 | B-side prescale code k, giving divide by 2^k |
| scale_a_i | input | 8 | A-side scale value N (0 means 256) |
| scale_a_wr_i | input | 1 | Strobe that loads scale_a_i and restarts the A divider |
| scale_b_i | input | 8 | B-side scale value N (0 means 256) |
| scale_b_wr_i | input | 1 | Strobe that loads scale_b_i and restarts the B divider |
| ch_tick_o | output | 8 | One-cycle clock-enable pulse per channel |

## Verification
The case hardest to reach from the ports is a scale reload that lands partway through a long count. To see that the old count is discarded, the divider has to be deep into a slow ratio at the moment the strobe arrives. The stimulus therefore sets a 400-cycle scaled period and waits for a pulse. It then writes a small value a few cycles later and checks that the next pulse arrives within a handful of cycles and is followed by the new short period. A second hard point is confirming that freeze has no effect when gating is off. For that, the bench measures an exact interval while freeze is held high with gating disabled.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int unsigned NSIDE = 2;

  // Side index serving a channel: pairs of channels alternate between sides.
  function automatic int unsigned side_of(input int unsigned ch);
    return (ch / 2) % NSIDE;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned NSIDE = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run_i,
  input  logic [NSIDE-1:0][SEL_W-1:0] sel_i,
  output logic [NSIDE-1:0]            tick_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (run_i) cnt <= cnt + 1'b1;
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [CNT_W:0] span;
    logic           hit;
    assign span = ((CNT_W+1)'(1) << sel_i[s]) - 1'b1;
    assign hit  = &(cnt | ~span[CNT_W-1:0]);

    always_ff @(posedge clk) begin
      if (rst) tick_o[s] <= 1'b0;
      else     tick_o[s] <= run_i & hit;
    end

    // R7
    tick_halt_chk: assert property (@(posedge clk) disable iff (rst)
      tick_o[s] |-> $past(run_i));
  end
endmodule

// File: rtl/pwm_scaler.sv
module pwm_scaler #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             pulse_o
);
  localparam int unsigned CW = VAL_W + 1;

  logic [CW-1:0] n_eff;
  logic [CW:0]   twice;
  logic [CW-1:0] load;
  logic [CW-1:0] cnt;

  assign n_eff = (val_i == '0) ? (CW)'(1) << VAL_W : {1'b0, val_i};
  assign twice = {n_eff, 1'b0};
  assign load  = CW'(twice - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else if (wr_i) begin
      cnt     <= load;
      pulse_o <= 1'b0;
    end else if (tick_i) begin
      if (cnt == '0) begin
        cnt     <= load;
        pulse_o <= 1'b1;
      end else begin
        cnt     <= cnt - 1'b1;
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R3
  scl_src_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(tick_i));
  // R3
  scl_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R9
  reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i) |-> !pulse_o);
endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel
  import pwm_tick_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] src_i,
  input  logic [NSIDE-1:0]  pre_i,
  input  logic [NSIDE-1:0]  scl_i,
  output logic [NUM_CH-1:0] tick_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned SD = side_of(c);
    always_ff @(posedge clk) begin
      if (rst) tick_o[c] <= 1'b0;
      else     tick_o[c] <= en_i[c] & (src_i[c] ? scl_i[SD] : pre_i[SD]);
    end

    // R8
    chan_gate_chk: assert property (@(posedge clk) disable iff (rst)
      tick_o[c] |-> $past(en_i[c]));
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned CNT_W  = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze_i,
  input  logic              frz_gate_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] src_scaled_i,
  input  logic [SEL_W-1:0]  pre_sel_a_i,
  input  logic [SEL_W-1:0]  pre_sel_b_i,
  input  logic [VAL_W-1:0]  scale_a_i,
  input  logic              scale_a_wr_i,
  input  logic [VAL_W-1:0]  scale_b_i,
  input  logic              scale_b_wr_i,
  output logic [NUM_CH-1:0] ch_tick_o
);
  logic                        halted;
  logic                        run;
  logic [NSIDE-1:0][SEL_W-1:0] sel;
  logic [NSIDE-1:0][VAL_W-1:0] val;
  logic [NSIDE-1:0]            wr;
  logic [NSIDE-1:0]            pre_tick;
  logic [NSIDE-1:0]            scl_tick;

  assign halted = frz_gate_i & freeze_i;
  assign run    = (|ch_en_i) & ~halted;
  assign sel    = {pre_sel_b_i, pre_sel_a_i};
  assign val    = {scale_b_i, scale_a_i};
  assign wr     = {scale_b_wr_i, scale_a_wr_i};

  pwm_prescaler #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NSIDE(NSIDE)) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .sel_i(sel), .tick_o(pre_tick)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_scl
    pwm_scaler #(.VAL_W(VAL_W)) u_scl (
      .clk(clk), .rst(rst), .tick_i(pre_tick[s]), .wr_i(wr[s]),
      .val_i(val[s]), .pulse_o(scl_tick[s])
    );
  end

  pwm_chan_sel #(.NUM_CH(NUM_CH)) u_sel (
    .clk(clk), .rst(rst), .en_i(ch_en_i), .src_i(src_scaled_i),
    .pre_i(pre_tick), .scl_i(scl_tick), .tick_o(ch_tick_o)
  );

  // R6
  frz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(halted, 1) && $past(halted, 2) && $past(halted, 3)) |-> (ch_tick_o == '0));
endmodule

// File: tb/sim_pwm_tick_gen.sv
module sim_pwm_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       freeze_i = 1'b0, frz_gate_i = 1'b0;
  logic [7:0] ch_en_i = '0, src_scaled_i = '0;
  logic [2:0] pre_sel_a_i = '0, pre_sel_b_i = '0;
  logic [7:0] scale_a_i = '0, scale_b_i = '0;
  logic       scale_a_wr_i = 1'b0, scale_b_wr_i = 1'b0;
  logic [7:0] ch_tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_tick_gen u0 (
    .clk(clk), .rst(rst), .freeze_i(freeze_i), .frz_gate_i(frz_gate_i),
    .ch_en_i(ch_en_i), .src_scaled_i(src_scaled_i),
    .pre_sel_a_i(pre_sel_a_i), .pre_sel_b_i(pre_sel_b_i),
    .scale_a_i(scale_a_i), .scale_a_wr_i(scale_a_wr_i),
    .scale_b_i(scale_b_i), .scale_b_wr_i(scale_b_wr_i),
    .ch_tick_o(ch_tick_o)
  );

  function automatic int exp_pre(input int k);
    return 1 << k;
  endfunction

  function automatic int exp_scl(input int k, input int n);
    return (1 << k) * 2 * ((n == 0) ? 256 : n);
  endfunction

  function automatic int side(input int ch);
    return (ch >> 1) & 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_pulse(input int ch, input int cap, output int t, output bit ok);
    ok = 1'b0;
    t = 0;
    for (int i = 0; i < cap; i++) begin
      @(negedge clk);
      if (ch_tick_o[ch]) begin
        t = cyc;
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input int ch, input int expv, input string req);
    int t0, t1, t2;
    bit a, b, c;
    int cap;
    cap = 3 * expv + 64;
    wait_pulse(ch, cap, t0, a);
    wait_pulse(ch, cap, t1, b);
    wait_pulse(ch, cap, t2, c);
    check(a && b && c && (t2 - t1 == expv), req, t2 - t1, expv);
  endtask

  task automatic quiet(input logic [7:0] mask, input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((ch_tick_o & mask) != '0) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic write_scale(input int sd, input int n);
    @(negedge clk);
    if (sd == 0) begin scale_a_i = 8'(n); scale_a_wr_i = 1'b1; end
    else         begin scale_b_i = 8'(n); scale_b_wr_i = 1'b1; end
    @(negedge clk);
    scale_a_wr_i = 1'b0;
    scale_b_wr_i = 1'b0;
  endtask

  task automatic scaled_case(input int ch, input int k, input int n, input string req);
    @(negedge clk);
    if (side(ch) == 0) pre_sel_a_i = 3'(k); else pre_sel_b_i = 3'(k);
    src_scaled_i = 8'(1 << ch);
    ch_en_i = 8'hFF;
    write_scale(side(ch), n);
    measure(ch, exp_scl(k, n), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int t, tw;
    bit ok;
    seed_dummy = $urandom(32'd2718);

    // R10: outputs quiet in reset even with channels enabled
    ch_en_i = 8'hFF;
    repeat (3) @(negedge clk);
    check(ch_tick_o == '0, "R10", ch_tick_o, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ch_tick_o == '0, "R10", ch_tick_o, 0);

    // R1 / R2: sweep A codes while B holds a mirrored code
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      pre_sel_a_i = 3'(k);
      pre_sel_b_i = 3'(7 - k);
      src_scaled_i = '0;
      measure(0, exp_pre(k), "R1");
      measure(2, exp_pre(7 - k), "R2");
    end

    // R4 / R5: channel 5 on A prescaled, channel 6 on B prescaled
    @(negedge clk);
    pre_sel_a_i = 3'd1;
    pre_sel_b_i = 3'd3;
    src_scaled_i = '0;
    measure(5, 2, "R4");
    measure(6, 8, "R4");

    // R3 directed corners: N=1 fastest, N=0 means 256
    scaled_case(1, 0, 1, "R3");
    scaled_case(4, 0, 0, "R3");
    scaled_case(3, 2, 0, "R3");
    scaled_case(7, 1, 3, "R4");

    // R5: same side, one channel scaled and one prescaled
    @(negedge clk);
    pre_sel_a_i = 3'd2;
    src_scaled_i = 8'b0000_0010;
    write_scale(0, 5);
    measure(0, 4, "R5");
    measure(1, 40, "R5");

    // R3 random samples (interval capped at 2048)
    for (int r = 0; r < 6; r++) begin
      int ch, k, n;
      ch = int'($urandom % 8);
      k = int'($urandom % 4);
      n = 1 + int'($urandom % (1024 >> k));
      if (n > 255) n = 255;
      scaled_case(ch, k, n, "R3");
    end

    // R6: freeze with gating on halts everything
    @(negedge clk);
    pre_sel_a_i = 3'd0;
    pre_sel_b_i = 3'd0;
    src_scaled_i = '0;
    ch_en_i = 8'hFF;
    frz_gate_i = 1'b1;
    freeze_i = 1'b1;
    repeat (5) @(negedge clk);
    quiet(8'hFF, 300, "R6");
    // R6: freeze without gating has no effect
    frz_gate_i = 1'b0;
    pre_sel_a_i = 3'd2;
    measure(0, 4, "R6");
    freeze_i = 1'b0;

    // R7: all channels disabled
    @(negedge clk);
    ch_en_i = '0;
    repeat (5) @(negedge clk);
    quiet(8'hFF, 300, "R7");

    // R8: one channel disabled while its neighbour runs
    @(negedge clk);
    ch_en_i = 8'b1111_0111;
    pre_sel_b_i = 3'd1;
    measure(2, 2, "R8");
    quiet(8'b0000_1000, 200, "R8");

    // R9: reload mid-count of a long scaled period
    @(negedge clk);
    ch_en_i = 8'hFF;
    pre_sel_a_i = 3'd0;
    src_scaled_i = 8'b0000_0001;
    write_scale(0, 200);
    wait_pulse(0, 1000, t, ok);
    repeat (10) @(negedge clk);
    write_scale(0, 2);
    tw = cyc;
    wait_pulse(0, 40, t, ok);
    check(ok && (t - tw) <= 8, "R9", t - tw, 8);
    measure(0, 4, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule